// File: doc/BRIEF.md
# Serial Port Register Block with Delayed Interrupts

This block is the byte-wide register face of a PC-style serial port. A host reaches eight offsets over a plain single-cycle read/write bus. On the character side, received bytes come from a stream port that shows an "available" flag, the head byte and a pop strobe. Transmitted bytes leave on a one-cycle strobe with the byte. No bit timing, baud generation, FIFO or modem pins sit inside the block. The divisor latch, line control and modem control registers are plain storage that the host can write and read back.

Interrupts are paced rather than immediate. Each source, receive and transmit, has a one-shot delay timer. When a timer runs out and its enable is still set, the single `irq` output rises and that source's status bit is set. Starting a timer that is already running reloads it with the full delay. Reading the data register or writing it drops `irq`. An identification read reports the highest-priority pending source and clears the transmit source. The delay is `DELAY_CYCLES`, which defaults to 450.

Top module: `sio_regblock`

## Requirements
- R1: After reset, every stored register reads 0x00, the identification read returns 0x01 and `irq` is low.
- R2: When line-control bit 7 is set, offsets 0 and 1 write and read the divisor low and high bytes, and a read at offset 0 does not pop. When the bit is clear, offset 0 is the data register and offset 1 is the interrupt-enable register.
- R3: A data read (offset 0, bank bit clear) returns the head byte and pulses `rx_pop` in the same cycle when a byte is available. Otherwise it returns 0x00 without a pop. At the next edge it clears `irq` and the receive status bit.
- R4: A data write (offset 0, bank bit clear) pulses `tx_valid` with `tx_data` equal to the written byte in the same cycle. At the next edge it clears `irq`, and if enable bit 1 is set it starts the transmit timer.
- R5: The identification read at offset 2 returns 0x04 when the receive status bit is set, 0x02 when only the transmit status bit is set, and 0x01 otherwise.
- R6: The identification read clears the transmit status bit and leaves the receive status bit and `irq` unchanged.
- R7: The line status read at offset 5 returns 0x60, with bit 0 equal to `rx_avail`.
- R8: Reads of offsets 6 and 7 return 0x00. Writes to offsets 2 and 7 change no readable register.
- R9: A timer started at edge t fires so that `irq` and its status bit are set at edge t+DELAY_CYCLES, provided enable bit 0 (receive) or bit 1 (transmit) is set then. A timer that is neither restarted nor cancelled fires once only.
- R10: Restarting a running timer reloads the full delay, so only one expiry follows, DELAY_CYCLES after the last start.
- R11: An interrupt-enable write starts the transmit timer if bit 1 is set and otherwise cancels it. It starts the receive timer if bit 0 is set and a byte is available, and otherwise cancels it. Unless both timers start, the write clears `irq`.
- R12: A rising edge of `rx_avail` while enable bit 0 is set raises `irq` at the next edge.
- R13: One cycle after a data read, if `rx_avail` is high and enable bit 0 is set, the receive timer restarts.
- R14: Offset 3 reads back the line-control byte and offset 4 reads back the modem-control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid in the access cycle, 0 otherwise |
| rx_avail | input | 1 | Receive stream holds a byte |
| rx_data | input | 8 | Head byte of the receive stream |
| rx_pop | output | 1 | Consume the head byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Interrupt output |

## Verification
A behavioural model of the register map, the two timers and the interrupt line is compared with the design on every cycle. Several patterns exercise the timers. A lone start shows the exact expiry cycle. A second start partway through the delay separates reloading from stacking. An enable-clearing write before expiry shows cancellation. Back-to-back queued bytes exercise the re-arm after a read. Setting both status bits at once shows the priority of the identification code, and a second identification read shows that the transmit bit was cleared. Bank switching with distinct divisor bytes separates the divisor latches from the data and enable registers.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam logic [2:0] OFS_DATA = 3'd0;
    localparam logic [2:0] OFS_IER  = 3'd1;
    localparam logic [2:0] OFS_IIR  = 3'd2;
    localparam logic [2:0] OFS_LCR  = 3'd3;
    localparam logic [2:0] OFS_MCR  = 3'd4;
    localparam logic [2:0] OFS_LSR  = 3'd5;
    localparam logic [2:0] OFS_MSR  = 3'd6;
    localparam logic [2:0] OFS_SCR  = 3'd7;

    localparam logic [7:0] IIR_RX_CODE   = 8'h04;
    localparam logic [7:0] IIR_TX_CODE   = 8'h02;
    localparam logic [7:0] IIR_NONE_CODE = 8'h01;
    localparam logic [7:0] LSR_IDLE_BITS = 8'h60;

    localparam int BANK_BIT  = 7;
    localparam int EN_RX_BIT = 0;
    localparam int EN_TX_BIT = 1;

    typedef struct packed {
        logic rx;
        logic tx;
    } src_t;

    typedef struct packed {
        logic [7:0] ier;
        logic [7:0] lcr;
        logic [7:0] mcr;
        logic [7:0] dll;
        logic [7:0] dlm;
    } regs_t;

    typedef struct packed {
        logic rd_data;
        logic wr_data;
        logic rd_iir;
        logic wr_ier;
        logic wr_lcr;
        logic wr_mcr;
        logic wr_dll;
        logic wr_dlm;
    } acc_t;

    function automatic logic [7:0] iir_code(input src_t st);
        if (st.rx)      return IIR_RX_CODE;
        else if (st.tx) return IIR_TX_CODE;
        else            return IIR_NONE_CODE;
    endfunction

endpackage

// File: rtl/sio_decode.sv
module sio_decode
    import sio_pkg::*;
(
    input  logic       sel,
    input  logic       we,
    input  logic [2:0] addr,
    input  logic       bank,
    output acc_t       acc
);
    logic rd, wr;

    always_comb begin
        rd = sel && !we;
        wr = sel && we;
        acc = '0;
        acc.rd_data = rd && (addr == OFS_DATA) && !bank;
        acc.wr_data = wr && (addr == OFS_DATA) && !bank;
        acc.wr_dll  = wr && (addr == OFS_DATA) && bank;
        acc.wr_ier  = wr && (addr == OFS_IER)  && !bank;
        acc.wr_dlm  = wr && (addr == OFS_IER)  && bank;
        acc.rd_iir  = rd && (addr == OFS_IIR);
        acc.wr_lcr  = wr && (addr == OFS_LCR);
        acc.wr_mcr  = wr && (addr == OFS_MCR);
    end
endmodule

// File: rtl/sio_delay_timer.sv
module sio_delay_timer #(
    parameter int DELAY_CYCLES = 450
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic cancel,
    output logic fire
);
    localparam int CW = $clog2(DELAY_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (start)         cnt <= CW'(DELAY_CYCLES);
        else if (cancel)        cnt <= '0;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign fire = (cnt == CW'(1)) && !start && !cancel;
endmodule

// File: rtl/sio_read_mux.sv
module sio_read_mux
    import sio_pkg::*;
(
    input  logic       rd_en,
    input  logic [2:0] addr,
    input  regs_t      regs,
    input  src_t       st,
    input  logic       rx_avail,
    input  logic [7:0] rx_data,
    output logic [7:0] rdata
);
    logic bank;

    always_comb begin
        bank  = regs.lcr[BANK_BIT];
        rdata = 8'h00;
        if (rd_en) begin
            case (addr)
                OFS_DATA: rdata = bank ? regs.dll : (rx_avail ? rx_data : 8'h00);
                OFS_IER:  rdata = bank ? regs.dlm : regs.ier;
                OFS_IIR:  rdata = iir_code(st);
                OFS_LCR:  rdata = regs.lcr;
                OFS_MCR:  rdata = regs.mcr;
                OFS_LSR:  rdata = LSR_IDLE_BITS | {7'd0, rx_avail};
                OFS_MSR:  rdata = 8'h00;
                OFS_SCR:  rdata = 8'h00;
                default:  rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/sio_regblock.sv
module sio_regblock
    import sio_pkg::*;
#(
    parameter int DELAY_CYCLES = 450
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_we,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rx_avail,
    input  logic [7:0] rx_data,
    output logic       rx_pop,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    output logic       irq
);
    localparam int NSRC  = 2;
    localparam int SRC_RX = 0;
    localparam int SRC_TX = 1;

    regs_t regs;
    src_t  st;
    acc_t  acc;
    logic  rx_prev;
    logic  rearm;

    logic [NSRC-1:0] t_start;
    logic [NSRC-1:0] t_cancel;
    logic [NSRC-1:0] t_fire;

    logic rx_fire, tx_fire, rx_edge, irq_clr;
    logic rx_post, tx_post;

    sio_decode u_dec (
        .sel  (bus_sel),
        .we   (bus_we),
        .addr (bus_addr),
        .bank (regs.lcr[BANK_BIT]),
        .acc  (acc)
    );

    sio_read_mux u_rmux (
        .rd_en    (bus_sel && !bus_we),
        .addr     (bus_addr),
        .regs     (regs),
        .st       (st),
        .rx_avail (rx_avail),
        .rx_data  (rx_data),
        .rdata    (bus_rdata)
    );

    always_comb begin
        t_start[SRC_RX]  = (acc.wr_ier && bus_wdata[EN_RX_BIT] && rx_avail)
                         || (rearm && rx_avail && regs.ier[EN_RX_BIT]);
        t_cancel[SRC_RX] = acc.wr_ier && !(bus_wdata[EN_RX_BIT] && rx_avail);
        t_start[SRC_TX]  = (acc.wr_ier && bus_wdata[EN_TX_BIT])
                         || (acc.wr_data && regs.ier[EN_TX_BIT]);
        t_cancel[SRC_TX] = acc.wr_ier && !bus_wdata[EN_TX_BIT];
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_tmr
        sio_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_tmr (
            .clk    (clk),
            .rst    (rst),
            .start  (t_start[g]),
            .cancel (t_cancel[g]),
            .fire   (t_fire[g])
        );
    end

    assign rx_fire = t_fire[SRC_RX];
    assign tx_fire = t_fire[SRC_TX];
    assign rx_post = rx_fire && regs.ier[EN_RX_BIT];
    assign tx_post = tx_fire && regs.ier[EN_TX_BIT];
    assign rx_edge = rx_avail && !rx_prev && regs.ier[EN_RX_BIT];
    assign irq_clr = acc.rd_data || acc.wr_data || (t_cancel[SRC_RX] || t_cancel[SRC_TX]);

    assign rx_pop   = acc.rd_data && rx_avail;
    assign tx_valid = acc.wr_data;
    assign tx_data  = bus_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs    <= '0;
            st      <= '0;
            irq     <= 1'b0;
            rx_prev <= 1'b0;
            rearm   <= 1'b0;
        end else begin
            rx_prev <= rx_avail;
            rearm   <= acc.rd_data;
            if (acc.wr_ier) regs.ier <= bus_wdata;
            if (acc.wr_lcr) regs.lcr <= bus_wdata;
            if (acc.wr_mcr) regs.mcr <= bus_wdata;
            if (acc.wr_dll) regs.dll <= bus_wdata;
            if (acc.wr_dlm) regs.dlm <= bus_wdata;
            if (acc.rd_data) st.rx <= 1'b0;
            if (rx_post)     st.rx <= 1'b1;
            if (acc.rd_iir)  st.tx <= 1'b0;
            if (tx_post)     st.tx <= 1'b1;
            if (irq_clr) irq <= 1'b0;
            if (rx_edge || rx_post || tx_post) irq <= 1'b1;
        end
    end
endmodule

// File: rtl/sio_regblock_chk.sv
module sio_regblock_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic       bus_we,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic [7:0] lcr,
    input logic       rx_avail,
    input logic       rx_pop,
    input logic       tx_valid,
    input logic       irq,
    input logic       rx_fire,
    input logic       tx_fire,
    input logic       rx_edge
);
    logic rd;
    assign rd = bus_sel && !bus_we;

    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> (rx_avail && rd && bus_addr == 3'd0)); // R3

    AST_NO_POP_IN_BANK: assert property (@(posedge clk) disable iff (rst)
        (rd && bus_addr == 3'd0 && lcr[7]) |-> !rx_pop); // R2

    AST_LSR_SHAPE: assert property (@(posedge clk) disable iff (rst)
        (rd && bus_addr == 3'd5) |-> (bus_rdata == (8'h60 | {7'd0, rx_avail}))); // R7

    AST_ZERO_HIGH_OFS: assert property (@(posedge clk) disable iff (rst)
        (rd && bus_addr[2:1] == 2'b11) |-> (bus_rdata == 8'h00)); // R8

    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(rx_fire || tx_fire || rx_edge)); // R9

    AST_TX_NOT_ON_READ: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (bus_sel && bus_we && !rx_pop)); // R4

    AST_WRITE_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !rx_fire && !tx_fire && !rx_edge) |=> !irq); // R4
endmodule

bind sio_regblock sio_regblock_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .lcr       (regs.lcr),
    .rx_avail  (rx_avail),
    .rx_pop    (rx_pop),
    .tx_valid  (tx_valid),
    .irq       (irq),
    .rx_fire   (rx_fire),
    .tx_fire   (tx_fire),
    .rx_edge   (rx_edge)
);

// File: tb/tb_sio_regblock.sv
module tb_sio_regblock;
    localparam int CLK_PERIOD = 10;
    localparam int DLY = 12;

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_sel, bus_we;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       rx_avail;
    logic [7:0] rx_data;
    logic       rx_pop, tx_valid, irq;
    logic [7:0] tx_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    sio_regblock #(.DELAY_CYCLES(DLY)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_avail(rx_avail), .rx_data(rx_data), .rx_pop(rx_pop),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    byte unsigned rxq[$];

    // reference model state
    int m_ier, m_lcr, m_mcr, m_dll, m_dlm;
    bit m_rxst, m_txst, m_irq, m_prev, m_rearm;
    int rx_cnt, tx_cnt;

    task automatic model_reset();
        m_ier = 0; m_lcr = 0; m_mcr = 0; m_dll = 0; m_dlm = 0;
        m_rxst = 0; m_txst = 0; m_irq = 0; m_prev = 0; m_rearm = 0;
        rx_cnt = 0; tx_cnt = 0;
    endtask

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int exp_rdata(bit s, bit w, int a, bit av, int hd);
        bit bank = m_lcr[7];
        if (!s || w) return 0;
        case (a)
            0: return bank ? m_dll : (av ? hd : 0);
            1: return bank ? m_dlm : m_ier;
            2: return m_rxst ? 8'h04 : (m_txst ? 8'h02 : 8'h01);
            3: return m_lcr;
            4: return m_mcr;
            5: return 8'h60 | int'(av);
            default: return 0;
        endcase
    endfunction

    task automatic cyc(bit s, bit w, int a, int d, string tag);
        bit av, bank, rdd, wrd, wier, riir, rxs, rxc, txs, txc, rxf, txf, clr;
        int hd;
        @(negedge clk);
        bus_sel = s; bus_we = w; bus_addr = 3'(a); bus_wdata = 8'(d);
        av = rxq.size() > 0;
        hd = av ? int'(rxq[0]) : 0;
        rx_avail = av; rx_data = 8'(hd);
        #1;
        bank = m_lcr[7];
        rdd  = s && !w && a == 0 && !bank;
        wrd  = s && w && a == 0 && !bank;
        wier = s && w && a == 1 && !bank;
        riir = s && !w && a == 2;
        check(tag, "rdata", int'(bus_rdata), exp_rdata(s, w, a, av, hd));
        check(tag, "rx_pop", int'(rx_pop), int'(rdd && av));
        check(tag, "tx_valid", int'(tx_valid), int'(wrd));
        if (wrd) check(tag, "tx_data", int'(tx_data), d);
        check(tag, "irq", int'(irq), int'(m_irq));
        @(posedge clk);
        rxs = (wier && d[0] && av) || (m_rearm && av && m_ier[0]);
        rxc = wier && !(d[0] && av);
        txs = (wier && d[1]) || (wrd && m_ier[1]);
        txc = wier && !d[1];
        rxf = rx_cnt == 1 && !rxs && !rxc;
        txf = tx_cnt == 1 && !txs && !txc;
        clr = rdd || wrd || rxc || txc;
        if (clr) m_irq = 0;
        if ((av && !m_prev && m_ier[0]) || (rxf && m_ier[0]) || (txf && m_ier[1])) m_irq = 1;
        if (rdd) m_rxst = 0;
        if (rxf && m_ier[0]) m_rxst = 1;
        if (riir) m_txst = 0;
        if (txf && m_ier[1]) m_txst = 1;
        rx_cnt = rxs ? DLY : (rxc ? 0 : (rx_cnt > 0 ? rx_cnt - 1 : 0));
        tx_cnt = txs ? DLY : (txc ? 0 : (tx_cnt > 0 ? tx_cnt - 1 : 0));
        m_prev = av;
        m_rearm = rdd;
        if (s && w) begin
            if (wier) m_ier = d;
            if (a == 0 && bank) m_dll = d;
            if (a == 1 && bank) m_dlm = d;
            if (a == 3) m_lcr = d;
            if (a == 4) m_mcr = d;
        end
        if (rdd && av) void'(rxq.pop_front());
    endtask

    task automatic wr(int a, int d, string tag); cyc(1, 1, a, d, tag); endtask
    task automatic rd(int a, string tag); cyc(1, 0, a, 0, tag); endtask
    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        rx_avail = 0; rx_data = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1 reset state
        idle(2, "R1");
        rd(1, "R1"); rd(2, "R1"); rd(3, "R1"); rd(4, "R1"); rd(0, "R1");
        // R2 / R14 banks and readback
        wr(3, 8'h83, "R14"); wr(0, 8'h5A, "R2"); wr(1, 8'hA5, "R2");
        rd(0, "R2"); rd(1, "R2"); rd(3, "R14");
        rxq.push_back(8'h99);
        rd(0, "R2");
        wr(3, 8'h03, "R14"); wr(4, 8'h1B, "R14"); rd(4, "R14"); rd(1, "R2");
        rd(0, "R3"); rd(0, "R3");
        // R8 ignored offsets
        wr(2, 8'hC7, "R8"); wr(7, 8'h3C, "R8");
        rd(6, "R8"); rd(7, "R8"); rd(1, "R8"); rd(3, "R8"); rd(4, "R8"); rd(2, "R8");
        // R11 / R9 transmit timer from enable write
        wr(1, 8'h02, "R11"); idle(DLY + 2, "R9");
        rd(2, "R5"); rd(2, "R6");
        // R4 / R10 retrigger via data writes
        wr(0, 8'h41, "R4"); idle(5, "R10"); wr(0, 8'h42, "R10"); idle(DLY + 2, "R10");
        // R11 cancel
        wr(0, 8'h43, "R4"); idle(4, "R11"); wr(1, 8'h00, "R11"); idle(DLY + 2, "R11");
        // R12 arrival, R7 status
        wr(1, 8'h01, "R12"); idle(2, "R12");
        rxq.push_back(8'h61); idle(3, "R12");
        rd(5, "R7"); rd(0, "R3"); rd(5, "R7"); idle(DLY + 2, "R13");
        // R13 rearm with more bytes queued
        rxq.push_back(8'h70); rxq.push_back(8'h71); rxq.push_back(8'h72);
        idle(2, "R12");
        rd(0, "R13"); idle(DLY + 3, "R13");
        rd(2, "R5");
        // R5 priority with both sources
        wr(1, 8'h03, "R11"); idle(DLY + 2, "R9");
        rd(2, "R5"); rd(2, "R6");
        rd(0, "R3"); idle(DLY + 3, "R13");
        rd(0, "R3"); idle(DLY + 3, "R13");
        rd(0, "R3"); rd(2, "R5");
        wr(1, 8'h00, "R11"); idle(4, "R11");
        rd(0, "R3"); rd(5, "R7");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule